// File: doc/BRIEF.md
# Edge-to-Edge Phase Interval Counter

This block measures the phase offset between two slow square waves. It counts cycles of a fast system clock from a rising edge on the reference input `ref_in` to the next rising edge on the feedback input `fb_in`. Both inputs are asynchronous to the clock. Each one passes through a synchronizer and an edge detector inside the single clock domain. As a result, no register in the block is clocked by either slow signal, and each register has exactly one driver.

A rising edge on `ref_in` clears the running count and arms a measurement. The first `fb_in` rising edge after that captures the interval into a hold register and pulses `valid_o` for one cycle. A new `ref_in` edge that arrives before the capture throws away the partial count and starts again from zero. If the interval is longer than the counter can represent, the captured value saturates and `overflow_o` is set for that result. The typical use is inputs near 1 kHz against a clock near 100 MHz. The default counter width holds a full 1 ms period at that clock rate.

Top module: `phase_interval_meter`

## Requirements
- R1: While `rst` is high and after it is released, with no input edges, `valid_o`, `overflow_o` and `interval_o` are all 0 and no measurement is armed.
- R2: If `ref_in` rises and `fb_in` rises d clock cycles later, with d no larger than MAX = 2^CNT_W-1, then the captured `interval_o` equals d and `overflow_o` is 0.
- R3: `valid_o` is high for exactly one clock cycle per captured result. `interval_o` and `overflow_o` keep that result until the next capture.
- R4: With SYNC_STAGES = 2, `valid_o` goes high right after the third rising clock edge that samples `fb_in` high. The first edge that sees `fb_in` high counts as the first.
- R5: A `ref_in` rising edge during an armed measurement restarts the count from zero. The next result is measured from the latest `ref_in` edge.
- R6: An `fb_in` rising edge while no measurement is armed is ignored. This covers edges before any `ref_in` edge and a second `fb_in` edge after a capture. In either case no `valid_o` pulse occurs and `interval_o` keeps its value.
- R7: If both edges are detected in the same cycle, the block captures `interval_o` = 0 with `overflow_o` = 0 and pulses `valid_o`. It leaves no measurement armed, so a later lone `fb_in` edge produces no result.
- R8: If d exceeds MAX, then `interval_o` = MAX and `overflow_o` = 1. An interval of exactly MAX gives `overflow_o` = 0. The next in-range result clears `overflow_o`.
- R9: Elaboration rejects CNT_W below 12 and SYNC_STAGES below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference wave; its rising edge starts a measurement |
| fb_in | input | 1 | Asynchronous compared wave; its rising edge ends a measurement |
| interval_o | output | CNT_W | Last captured interval in clock cycles |
| valid_o | output | 1 | One-cycle strobe marking a new captured interval |
| overflow_o | output | 1 | Set when the last captured interval saturated |

## Verification
Random offsets between a `ref_in` edge and the following `fb_in` edge are compared with the expected count. This shows whether the captured value is off by one cycle at either end of the window. Directed cases cover the following:
- edges in the same cycle, which tell the zero-result path apart from a normal capture;
- `fb_in` edges with nothing armed, which must leave the held result unchanged;
- a second `ref_in` edge in mid-measurement, which shows whether the count restarts or keeps accumulating;
- offsets of exactly MAX and just above it, which separate saturation from a correct full-range count.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;

   typedef enum logic [0:0] {
      PM_IDLE  = 1'b0,
      PM_ARMED = 1'b1
   } pm_state_e;

   // Smallest legal counter width and synchronizer depth
   localparam int unsigned PM_MIN_CNT_W  = 12;
   localparam int unsigned PM_MIN_STAGES = 2;

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[g] <= 1'b0;
               else     chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

   // R4: a detected edge lasts one cycle only
   a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);

endmodule

// File: rtl/pm_interval_ctr.sv
module pm_interval_ctr
   import phase_meter_pkg::*;
#(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             stop_i,
   output logic             cap_o,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             cap_ovf_o,
   output logic             armed_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   pm_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             at_max;
   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      at_max  = (cnt_q == CNT_MAX);
      cnt_inc = at_max ? cnt_q : cnt_q + 1'b1;
   end

   assign armed_o   = (state_q == PM_ARMED);
   assign cap_o     = stop_i & (start_i | armed_o);
   assign cap_val_o = start_i ? '0 : cnt_inc;
   assign cap_ovf_o = start_i ? 1'b0 : (ovf_q | at_max);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PM_IDLE;
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
      end else if (start_i && !stop_i) begin
         state_q <= PM_ARMED;
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
      end else if (stop_i) begin
         state_q <= PM_IDLE;
      end else if (state_q == PM_ARMED) begin
         cnt_q <= cnt_inc;
         if (at_max) ovf_q <= 1'b1;
      end
   end

   // R5: a lone start edge leaves an armed, cleared count
   a_r5_restart_clear: assert property (@(posedge clk) disable iff (rst)
      (start_i && !stop_i) |=> (armed_o && cnt_q == '0 && !ovf_q));

   // R8: the running count never moves down while armed
   a_r8_count_monotonic: assert property (@(posedge clk) disable iff (rst)
      (armed_o && !start_i && !stop_i) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/pm_result_hold.sv
module pm_result_hold #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_i,
   input  logic [CNT_W-1:0] cap_val_i,
   input  logic             cap_ovf_i,
   output logic [CNT_W-1:0] value_o,
   output logic             ovf_o,
   output logic             valid_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         value_o <= '0;
         ovf_o   <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= cap_i;
         if (cap_i) begin
            value_o <= cap_val_i;
            ovf_o   <= cap_ovf_i;
         end
      end
   end

   // R3: the held result only changes with a strobe
   a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> ($stable(value_o) && $stable(ovf_o)) or $past(rst));

endmodule

// File: rtl/phase_interval_meter.sv
module phase_interval_meter
   import phase_meter_pkg::*;
#(
   parameter int unsigned CNT_W       = 17,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_in,
   input  logic             fb_in,
   output logic [CNT_W-1:0] interval_o,
   output logic             valid_o,
   output logic             overflow_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R9: elaboration-time parameter checks
   generate
      if (CNT_W < PM_MIN_CNT_W) begin : g_bad_width
         $error("phase_interval_meter: CNT_W below minimum");
      end
      if (SYNC_STAGES < PM_MIN_STAGES) begin : g_bad_sync
         $error("phase_interval_meter: SYNC_STAGES below minimum");
      end
   endgenerate

   logic             ref_rise;
   logic             fb_rise;
   logic             cap;
   logic [CNT_W-1:0] cap_val;
   logic             cap_ovf;
   logic             armed;

   pm_edge_sync #(.STAGES(SYNC_STAGES)) i_ref_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ref_in),
      .rise_o   (ref_rise)
   );

   pm_edge_sync #(.STAGES(SYNC_STAGES)) i_fb_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (fb_in),
      .rise_o   (fb_rise)
   );

   pm_interval_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk       (clk),
      .rst       (rst),
      .start_i   (ref_rise),
      .stop_i    (fb_rise),
      .cap_o     (cap),
      .cap_val_o (cap_val),
      .cap_ovf_o (cap_ovf),
      .armed_o   (armed)
   );

   pm_result_hold #(.CNT_W(CNT_W)) i_hold (
      .clk       (clk),
      .rst       (rst),
      .cap_i     (cap),
      .cap_val_i (cap_val),
      .cap_ovf_i (cap_ovf),
      .value_o   (interval_o),
      .ovf_o     (overflow_o),
      .valid_o   (valid_o)
   );

   // R3: strobe is a single-cycle pulse
   a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   // R6: a stop edge with nothing armed yields no result
   a_r6_stray_stop: assert property (@(posedge clk) disable iff (rst)
      (fb_rise && !ref_rise && !armed) |=> !valid_o);

   // R7: coincident edges give a zero result and stay unarmed
   a_r7_coincident: assert property (@(posedge clk) disable iff (rst)
      (fb_rise && ref_rise) |=> (valid_o && interval_o == '0 && !overflow_o && !armed));

   // R8: overflow implies a saturated value
   a_r8_sat_value: assert property (@(posedge clk) disable iff (rst)
      overflow_o |-> (interval_o == CNT_MAX));

endmodule

// File: tb/test_phase_interval_meter.sv
`timescale 1ns/1ps
module test_phase_interval_meter;

   localparam int unsigned TB_W   = 12;
   localparam int          TB_MAX = (1 << TB_W) - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            ref_in = 1'b0;
   logic            fb_in = 1'b0;
   logic [TB_W-1:0] interval_o;
   logic            valid_o;
   logic            overflow_o;

   int checks = 0;
   int errors = 0;
   int vcnt   = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   phase_interval_meter #(.CNT_W(TB_W), .SYNC_STAGES(2)) i_phase_interval_meter (
      .clk        (clk),
      .rst        (rst),
      .ref_in     (ref_in),
      .fb_in      (fb_in),
      .interval_o (interval_o),
      .valid_o    (valid_o),
      .overflow_o (overflow_o)
   );

   always @(negedge clk) if (valid_o) vcnt++;

   function automatic int exp_interval(input int d);
      return (d > TB_MAX) ? TB_MAX : d;
   endfunction

   function automatic bit exp_ovf(input int d);
      return (d > TB_MAX);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One measurement: ref rises, fb rises d cycles later
   task automatic measure(input int d, input string req);
      int n;
      @(negedge clk);
      ref_in = 1'b1;
      for (int i = 0; i < d; i++) @(negedge clk);
      fb_in = 1'b1;
      n = 0;
      while (n < 20) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (valid_o) break;
      end
      check(n == 3, "R4 latency", n, 3);
      check(int'(interval_o) == exp_interval(d), req, interval_o, exp_interval(d));
      check(overflow_o == exp_ovf(d), "R8 overflow flag", overflow_o, exp_ovf(d));
      @(negedge clk);
      check(valid_o == 1'b0, "R3 strobe width", valid_o, 0);
      ref_in = 1'b0;
      fb_in  = 1'b0;
      idle(4);
   endtask

   initial begin
      int held;
      int v0;
      void'($urandom(32'd4711));
      idle(3);
      check(valid_o == 1'b0 && overflow_o == 1'b0 && interval_o == '0, "R1 in reset",
            {valid_o, overflow_o}, 0);
      rst = 1'b0;
      idle(5);
      check(valid_o == 1'b0 && interval_o == '0 && vcnt == 0, "R1 after reset", vcnt, 0);

      // R6: fb edge before any ref edge
      fb_in = 1'b1; idle(8); fb_in = 1'b0; idle(4);
      check(vcnt == 0, "R6 stray fb before arm", vcnt, 0);

      // R2 directed
      measure(1,  "R2 d=1");
      measure(37, "R2 d=37");

      // R6: second fb edge after a capture
      held = interval_o; v0 = vcnt;
      fb_in = 1'b1; idle(8); fb_in = 1'b0; idle(4);
      check(vcnt == v0, "R6 fb after capture pulses", vcnt, v0);
      check(int'(interval_o) == held, "R6 held value kept", interval_o, held);

      // R7: coincident edges
      measure(0, "R7 coincident zero");
      v0 = vcnt;
      fb_in = 1'b1; idle(8); fb_in = 1'b0; idle(4);
      check(vcnt == v0, "R7 not armed after coincident", vcnt, v0);
      check(interval_o == '0, "R7 value kept zero", interval_o, 0);

      // R5: restart mid-measurement
      @(negedge clk); ref_in = 1'b1;
      idle(20); ref_in = 1'b0; idle(3);
      v0 = vcnt;
      check(vcnt == v0, "R5 no result on restart", vcnt, v0);
      measure(15, "R5 restart interval");

      // R8: boundary and saturation
      measure(TB_MAX, "R8 exactly MAX");
      measure(TB_MAX + 1, "R8 MAX+1 saturates");
      measure(TB_MAX + 700, "R8 far over saturates");
      measure(9, "R8 overflow cleared");

      // R2/R3 random intervals
      for (int k = 0; k < 30; k++) begin
         int d;
         d = $urandom_range(0, 300);
         v0 = vcnt;
         measure(d, "R2 random");
         check(vcnt == v0 + 1, "R3 one strobe per result", vcnt, v0 + 1);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule